// File: doc/BRIEF.md
# Multi-output encoded-ratio clock divider

This block derives four clock-enable pulse trains (core, high-speed bus, low-speed bus, memory) from a single fast source clock. Each train's ratio comes from a 4-bit code in a shared 32-bit control word. The word is written through a one-cycle write strobe and can be read back at all times. The code picks an entry from a fixed, non-uniform ratio table. It does not divide by code plus one.

A ratio update needs two things. An update-enable bit in the control word must be set, and it is applied only when that output's counter wraps. As a result, no enable period is ever cut short by a change. A further control bit drives a half-rate branch enable. That enable either follows the source at full rate or pulses on every other cycle.

Top module: `clk_div_bank`

## Requirements
- R1: A cycle with wr_en_i high stores all 32 bits of wr_data_i, and the stored word appears on ctrl_o in the next cycle. After reset ctrl_o is 0.
- R2: Codes 0 to 9 select the ratios 1, 2, 3, 4, 6, 8, 12, 16, 24 and 32 respectively. Each tick_o bit goes high for one cycle out of every ratio cycles.
- R3: Codes 10 to 15 each give a ratio of 32.
- R4: A ratio of 1 holds the enable high in every cycle. After reset all codes are 0, so all four tick_o bits are high in every cycle.
- R5: tick_o[k] takes its code from ctrl bits [4k+3:4k]: bit 0 core, bit 1 high-speed bus, bit 2 low-speed bus, bit 3 memory. The four outputs run independently.
- R6: A new ratio takes effect only at the output's counter wrap. An interval that is already in progress completes at the old ratio.
- R7: When ctrl bit 22 (update enable) is 0, written codes are stored and read back but do not change any ratio. Writing them again later with bit 22 at 1 applies them.
- R8: When ctrl bit 21 is 1, half_tick_o is high in every cycle. When bit 21 is 0, half_tick_o is high in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast source clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Control word write strobe |
| wr_data_i | input | 32 | Control word write data |
| ctrl_o | output | 32 | Stored control word |
| tick_o | output | 4 | Enables: core, high-speed bus, low-speed bus, memory |
| half_tick_o | output | 1 | Half-rate branch enable |

## Verification
The hardest case to reach is a code change that lands partway through a long interval. Bringing it about needs a known phase between the write and the counter. To get there, the stimulus waits for an observed core tick at ratio 32, writes a ratio-1 code five cycles later, and then expects one full 32-cycle interval followed by single-cycle intervals. Locked writes with bit 22 clear are checked two ways: through the read-back word and through intervals that stay unchanged, before the same word is written again with bit 22 set.

// File: rtl/clk_div_pkg.sv
package clk_div_pkg;
  localparam int unsigned NUM_OUT   = 4;
  localparam int unsigned CODE_W    = 4;
  localparam int unsigned REG_W     = 32;
  localparam int unsigned MAX_RATIO = 32;
  localparam int unsigned CNT_W     = $clog2(MAX_RATIO);
  localparam int unsigned RATIO_W   = $clog2(MAX_RATIO + 1);
  localparam int unsigned UPD_BIT   = 22;
  localparam int unsigned HALF_BIT  = 21;

  function automatic logic [RATIO_W-1:0] code_to_ratio(input logic [CODE_W-1:0] code);
    case (code)
      4'd0:    code_to_ratio = RATIO_W'(1);
      4'd1:    code_to_ratio = RATIO_W'(2);
      4'd2:    code_to_ratio = RATIO_W'(3);
      4'd3:    code_to_ratio = RATIO_W'(4);
      4'd4:    code_to_ratio = RATIO_W'(6);
      4'd5:    code_to_ratio = RATIO_W'(8);
      4'd6:    code_to_ratio = RATIO_W'(12);
      4'd7:    code_to_ratio = RATIO_W'(16);
      4'd8:    code_to_ratio = RATIO_W'(24);
      default: code_to_ratio = RATIO_W'(MAX_RATIO); // clamp past table end
    endcase
  endfunction
endpackage

// File: rtl/ctrl_reg.sv
module ctrl_reg #(
  parameter int unsigned REG_W = clk_div_pkg::REG_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wr_data_i,
  output logic [REG_W-1:0] ctrl_o
);
  logic [REG_W-1:0] ctrl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ctrl_q <= '0;
    else if (wr_en_i) ctrl_q <= wr_data_i;
  end

  assign ctrl_o = ctrl_q;

  AST_WRITE_STORES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> ctrl_q == $past(wr_data_i)); // R1
  AST_HOLD_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(ctrl_q)); // R1
endmodule

// File: rtl/div_chan.sv
module div_chan #(
  parameter int unsigned CODE_W  = clk_div_pkg::CODE_W,
  parameter int unsigned CNT_W   = clk_div_pkg::CNT_W,
  parameter int unsigned RATIO_W = clk_div_pkg::RATIO_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CODE_W-1:0] code_i,
  input  logic              upd_en_i,
  output logic              tick_o
);
  logic [RATIO_W-1:0] act_q, nxt_ratio;
  logic [CNT_W-1:0]   cnt_q;
  logic               wrap;

  assign wrap      = (cnt_q == '0);
  assign nxt_ratio = upd_en_i ? clk_div_pkg::code_to_ratio(code_i) : act_q;

  // ratio is latched only at wrap so the running interval is never shortened
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= RATIO_W'(1);
      cnt_q <= '0;
    end else if (wrap) begin
      act_q <= nxt_ratio;
      cnt_q <= CNT_W'(nxt_ratio - RATIO_W'(1));
    end else begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign tick_o = wrap;

  AST_CNT_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    RATIO_W'(cnt_q) < act_q); // R2
  AST_NO_SKIP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wrap |=> cnt_q == $past(cnt_q) - 1'b1); // R6
  AST_RATIO_STABLE_MID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wrap |=> $stable(act_q)); // R6
  AST_LOCKED_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wrap && !upd_en_i) |=> $stable(act_q)); // R7
  AST_UNIT_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wrap && act_q == RATIO_W'(1) && !upd_en_i) |=> tick_o); // R4
endmodule

// File: rtl/half_branch.sv
module half_branch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic full_i,
  output logic tick_o
);
  logic tgl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tgl_q <= 1'b1;
    else         tgl_q <= ~tgl_q;
  end

  assign tick_o = full_i | tgl_q;

  AST_HALF_ALT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!full_i && !tick_o) |=> tick_o); // R8
endmodule

// File: rtl/clk_div_bank.sv
module clk_div_bank
  import clk_div_pkg::*;
#(
  parameter int unsigned N_OUT  = NUM_OUT,
  parameter int unsigned C_W    = CODE_W,
  parameter int unsigned R_W    = REG_W,
  parameter int unsigned UPD_B  = UPD_BIT,
  parameter int unsigned HALF_B = HALF_BIT
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [R_W-1:0]   wr_data_i,
  output logic [R_W-1:0]   ctrl_o,
  output logic [N_OUT-1:0] tick_o,
  output logic             half_tick_o
);
  logic [R_W-1:0] ctrl;

  ctrl_reg #(.REG_W(R_W)) u_ctrl (
    .clk_i, .rst_ni, .wr_en_i, .wr_data_i, .ctrl_o(ctrl)
  );

  assign ctrl_o = ctrl;

  for (genvar k = 0; k < N_OUT; k++) begin : g_chan
    div_chan #(.CODE_W(C_W)) u_chan (
      .clk_i,
      .rst_ni,
      .code_i  (ctrl[k*C_W +: C_W]),
      .upd_en_i(ctrl[UPD_B]),
      .tick_o  (tick_o[k])
    );
  end

  half_branch u_half (
    .clk_i, .rst_ni, .full_i(ctrl[HALF_B]), .tick_o(half_tick_o)
  );

  AST_FULL_RATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl[HALF_B] |-> half_tick_o); // R8
endmodule

// File: tb/clk_div_bank_tb.sv
module clk_div_bank_tb;
  localparam time CLK_PERIOD = 10ns;

  typedef struct { int val; string tag; } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] ctrl;
  logic [3:0]  tick;
  logic        half_tick;

  int errors = 0;
  int checks = 0;
  exp_t exp_q [4][$];
  int gap [4];

  always #(CLK_PERIOD/2) clk = ~clk;

  clk_div_bank u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .ctrl_o(ctrl), .tick_o(tick), .half_tick_o(half_tick)
  );

  function automatic int ratio_of(int code);
    case (code)
      0: return 1;  1: return 2;  2: return 3;  3: return 4;  4: return 6;
      5: return 8;  6: return 12; 7: return 16; 8: return 24;
      default: return 32;
    endcase
  endfunction

  function automatic logic [31:0] word(bit upd, bit half, int c0, int c1, int c2, int c3);
    return (32'(upd) << 22) | (32'(half) << 21) |
           (32'(c3 & 15) << 12) | (32'(c2 & 15) << 8) | (32'(c1 & 15) << 4) | 32'(c0 & 15);
  endfunction

  task automatic check(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // monitor: measures the interval ending at each tick and pops the scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      for (int k = 0; k < 4; k++) begin
        gap[k]++;
        if (tick[k]) begin
          if (exp_q[k].size() > 0) begin
            exp_t e;
            e = exp_q[k].pop_front();
            check(gap[k] == e.val, e.tag, $sformatf("interval ch%0d", k), gap[k], e.val);
          end
          gap[k] = 0;
        end
      end
    end else begin
      for (int k = 0; k < 4; k++) gap[k] = 0;
    end
  end

  task automatic wr(logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
    #1;
  endtask

  task automatic push(int k, int val, string tag, int n);
    exp_t e;
    e.val = val; e.tag = tag;
    for (int i = 0; i < n; i++) exp_q[k].push_back(e);
  endtask

  task automatic drain();
    while (exp_q[0].size() + exp_q[1].size() + exp_q[2].size() + exp_q[3].size() > 0)
      @(negedge clk);
  endtask

  task automatic count_half(int exp, string tag);
    int hi = 0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      hi += int'(half_tick);
    end
    check(hi == exp, tag, "half-rate highs in 8 cycles", hi, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R6 watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int old;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 / R4 reset state
    check(ctrl == 32'h0, "R1", "ctrl after reset", int'(ctrl), 0);
    check(tick == 4'hF, "R4", "tick after reset", int'(tick), 15);
    #1;
    for (int k = 0; k < 4; k++) push(k, 1, "R4", 3);
    drain();
    count_half(4, "R8"); // bit21 clear: every other cycle

    // R2 / R3: sweep every code on all outputs
    old = 1;
    for (int c = 0; c < 16; c++) begin
      wr(word(1, 0, c, c, c, c));
      check(ctrl == word(1, 0, c, c, c, c), "R1", "ctrl readback", int'(ctrl), int'(word(1, 0, c, c, c, c)));
      idle(old + 2);
      for (int k = 0; k < 4; k++) push(k, ratio_of(c), (c < 10) ? "R2" : "R3", 3);
      drain();
      old = ratio_of(c);
    end

    // R5: distinct code per field
    wr(word(1, 0, 1, 2, 3, 4));
    idle(old + 2);
    push(0, 2, "R5", 3); push(1, 3, "R5", 3); push(2, 4, "R5", 3); push(3, 6, "R5", 3);
    drain();

    // R7: locked writes stored but not applied
    wr(word(1, 0, 2, 2, 2, 2));
    idle(8);
    for (int k = 0; k < 4; k++) push(k, 3, "R7", 2);
    drain();
    wr(word(0, 0, 5, 5, 5, 5));
    check(ctrl == word(0, 0, 5, 5, 5, 5), "R7", "locked word readback", int'(ctrl), int'(word(0, 0, 5, 5, 5, 5)));
    idle(5);
    for (int k = 0; k < 4; k++) push(k, 3, "R7", 3);
    drain();
    wr(word(1, 0, 5, 5, 5, 5));
    idle(5);
    for (int k = 0; k < 4; k++) push(k, 8, "R7", 3);
    drain();

    // R6: mid-period change, 32 -> 1 on core output
    wr(word(1, 0, 9, 9, 9, 9));
    idle(10);
    for (int k = 0; k < 4; k++) push(k, 32, "R6", 1);
    drain();
    @(negedge clk);
    while (!tick[0]) @(negedge clk);
    idle(5);
    wr(word(1, 0, 0, 9, 9, 9));
    push(0, 32, "R6", 1);
    push(0, 1, "R6", 3);
    drain();

    // R8: full-rate half branch
    wr(word(1, 1, 0, 0, 0, 0));
    count_half(8, "R8");
    wr(word(1, 0, 0, 0, 0, 0));
    @(negedge clk);
    count_half(4, "R8");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule